// File: doc/BRIEF.md
# Shared-Offset Serial Data Port with Transmit and Receive Queues

This block is the register-side front end of a serial port. One bus offset serves both directions: a write puts a character into the transmit path, and a read takes the oldest character out of the receive path. With queueing switched on, each direction buffers up to `DEPTH` characters. With it switched off, each direction keeps exactly one character.

On the serializer side the block offers the next outgoing character with a valid/pop handshake. It accepts each incoming character with a single-cycle push strobe. A status register reports three things: whether the transmit side is empty, whether received data is waiting, and whether a character was lost because the receive side was full. When the receive side is full, the characters already stored are kept and the newcomer is thrown away.

A line-control bit redirects the shared offset to a divisor-latch byte, so software can program the baud divisor without disturbing either data path. Bus data is byte-wide in bits 7:0 of a 32-bit word. Reads are combinational on the addressed cycle, and any removal takes effect at that clock edge.

Top module: `uart_dport`

## Requirements
- R1: After reset the status register (offset 0x14) reads 0x20, `tx_valid` is 0, and the overrun flag is clear.
- R2: Only bits 7:0 of a data write are stored. Bits 31:8 of every read return zero.
- R3: With queue mode off (FIFO control at offset 0x8, bit 0 = 0), each path holds one character. A second data write before the first is popped is dropped.
- R4: With queue mode on, a read of offset 0x0 returns the oldest receive entry and removes it. Characters come out in arrival order. A read of an empty receive path returns 0.
- R5: A character pushed while the receive path is full (1 entry in single mode, `DEPTH` in queue mode) is discarded, the stored entries stay unchanged, and overrun (status bit 1) is set. This holds even when a read happens in the same cycle.
- R6: Overrun is sticky until the status register is read. The read returns it set and then clears it. Status bit 0 is 1 whenever received data is waiting.
- R7: Status bit 5 is 1 exactly when the transmit path holds no data. It drops in the cycle after a write, and `tx_valid` rises in that same cycle.
- R8: In queue mode, `DEPTH` (16) writes are accepted from empty. A further write while full is dropped and leaves the contents unchanged.
- R9: `tx_data` shows the oldest transmit entry while `tx_valid` is 1. `tx_pop` removes it, so characters leave in write order.
- R10: While line control (offset 0xC) bit 7 is 1, offset 0x0 reads and writes the divisor-latch byte and neither data path changes.
- R11: Any write to the FIFO control register empties both paths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, same cycle |
| tx_valid | output | 1 | Transmit character available |
| tx_data | output | DATA_W | Oldest transmit character |
| tx_pop | input | 1 | Serializer takes the character |
| rx_push | input | 1 | Incoming character strobe |
| rx_data | input | DATA_W | Incoming character |

## Verification
Directed runs fill each path to exactly its capacity and one beyond, in both modes. These runs separate a correct full threshold from an off-by-one and show that the stored data survives an overrun rather than being overwritten. Toggling the divisor-access bit around data traffic shows whether the shared offset really leaves the paths alone. A long seeded random mix of pushes, reads, writes, pops, status reads and mode changes is compared with a queue model. It exposes ordering faults, mistakes in the same-cycle status clear, and flush faults that directed runs would not reach.

// File: rtl/dport_pkg.sv
package dport_pkg;
   localparam int unsigned OFS_DATA = 0;
   localparam int unsigned OFS_FCTL = 8;
   localparam int unsigned OFS_LCTL = 12;
   localparam int unsigned OFS_STAT = 20;

   localparam int unsigned ST_DR   = 0;
   localparam int unsigned ST_OVR  = 1;
   localparam int unsigned ST_THRE = 5;
   localparam int unsigned LC_DIVA = 7;
   localparam int unsigned FC_QEN  = 0;

   typedef struct packed {
      logic dat_wr;
      logic dat_rd;
      logic div_wr;
      logic fctl_wr;
      logic lctl_wr;
      logic stat_rd;
   } dport_dec_t;
endpackage

// File: rtl/dport_fifo.sv
module dport_fifo #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          one_deep,
   input  logic          push,
   input  logic          pop,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  head,
   output logic          full,
   output logic          empty,
   output logic [CW-1:0] count
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("dport_fifo: DEPTH must be at least 2");
      end
      if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_pow2
         $error("dport_fifo: DEPTH must be a power of two");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = one_deep ? (count != '0) : (count == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (flush) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         if (do_push && !do_pop)      count <= count + 1'b1;
         else if (do_pop && !do_push) count <= count - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wptr] <= wdata;
   end
endmodule

// File: rtl/dport_decode.sv
module dport_decode
   import dport_pkg::*;
#(
   parameter int unsigned ADDR_W = 5
) (
   input  logic              sel,
   input  logic              wr,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   input  logic              diva,
   output dport_dec_t        dec
);
   always_comb begin
      dec = '0;
      if (sel) begin
         if (addr == ADDR_W'(OFS_DATA)) begin
            if (diva) dec.div_wr = wr;
            else begin
               dec.dat_wr = wr;
               dec.dat_rd = rd && !wr;
            end
         end else if (addr == ADDR_W'(OFS_FCTL)) begin
            dec.fctl_wr = wr;
         end else if (addr == ADDR_W'(OFS_LCTL)) begin
            dec.lctl_wr = wr;
         end else if (addr == ADDR_W'(OFS_STAT)) begin
            dec.stat_rd = rd && !wr;
         end
      end
   end
endmodule

// File: rtl/dport_status.sv
module dport_status
   import dport_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ovr_set,
   input  logic       ovr_clr,
   input  logic       rx_ready,
   input  logic       tx_idle,
   output logic       ovr,
   output logic [7:0] stat_byte
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovr <= 1'b0;
      else if (ovr_set) ovr <= 1'b1;
      else if (ovr_clr) ovr <= 1'b0;
   end

   always_comb begin
      stat_byte          = '0;
      stat_byte[ST_DR]   = rx_ready;
      stat_byte[ST_OVR]  = ovr;
      stat_byte[ST_THRE] = tx_idle;
   end
endmodule

// File: rtl/uart_dport.sv
module uart_dport
   import dport_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned BUS_W  = 32,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   input  logic              tx_pop,
   input  logic              rx_push,
   input  logic [DATA_W-1:0] rx_data
);
   generate
      if (BUS_W < DATA_W || DATA_W < 8) begin : g_bad_width
         $error("uart_dport: BUS_W must cover DATA_W, DATA_W at least 8");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("uart_dport: ADDR_W too small for the register offsets");
      end
   endgenerate

   dport_dec_t        dec;
   logic [7:0]        lctl;
   logic              qen;
   logic [DATA_W-1:0] div_lo;
   logic              flush;
   logic [DATA_W-1:0] rx_head;
   logic              rx_full, rx_empty, tx_full, tx_empty;
   logic [CW-1:0]     rx_count, tx_count;
   logic              ovr;
   logic [7:0]        stat_byte;

   dport_decode #(.ADDR_W(ADDR_W)) u_dec (
      .sel  (bus_sel),
      .wr   (bus_wr),
      .rd   (bus_rd),
      .addr (bus_addr),
      .diva (lctl[LC_DIVA]),
      .dec  (dec)
   );

   assign flush = dec.fctl_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lctl   <= '0;
         qen    <= 1'b0;
         div_lo <= '0;
      end else begin
         if (dec.lctl_wr) lctl   <= bus_wdata[7:0];
         if (dec.fctl_wr) qen    <= bus_wdata[FC_QEN];
         if (dec.div_wr)  div_lo <= bus_wdata[DATA_W-1:0];
      end
   end

   dport_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .one_deep (!qen),
      .push     (dec.dat_wr),
      .pop      (tx_pop),
      .wdata    (bus_wdata[DATA_W-1:0]),
      .head     (tx_data),
      .full     (tx_full),
      .empty    (tx_empty),
      .count    (tx_count)
   );

   dport_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .one_deep (!qen),
      .push     (rx_push),
      .pop      (dec.dat_rd),
      .wdata    (rx_data),
      .head     (rx_head),
      .full     (rx_full),
      .empty    (rx_empty),
      .count    (rx_count)
   );

   assign tx_valid = !tx_empty;

   dport_status u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .ovr_set   (rx_push && rx_full),
      .ovr_clr   (dec.stat_rd),
      .rx_ready  (!rx_empty),
      .tx_idle   (tx_empty),
      .ovr       (ovr),
      .stat_byte (stat_byte)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && bus_rd) begin
         if (bus_addr == ADDR_W'(OFS_DATA)) begin
            if (lctl[LC_DIVA])  bus_rdata[DATA_W-1:0] = div_lo;
            else if (!rx_empty) bus_rdata[DATA_W-1:0] = rx_head;
         end else if (bus_addr == ADDR_W'(OFS_LCTL)) begin
            bus_rdata[7:0] = lctl;
         end else if (bus_addr == ADDR_W'(OFS_STAT)) begin
            bus_rdata[7:0] = stat_byte;
         end
      end
   end
endmodule

// File: rtl/dport_chk.sv
module dport_chk #(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              diva,
   input logic              flush,
   input logic              dat_wr,
   input logic              dat_rd,
   input logic              stat_rd,
   input logic              tx_valid,
   input logic              tx_pop,
   input logic              tx_full,
   input logic [CW-1:0]     tx_count,
   input logic              rx_push,
   input logic              rx_full,
   input logic [CW-1:0]     rx_count,
   input logic              ovr,
   input logic [7:0]        stat_byte
);
   AST_THRE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      stat_byte[5] == !tx_valid); // R7

   AST_RX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push && rx_full && !dat_rd && !flush |=> rx_full && $stable(rx_count)); // R5

   AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push && rx_full |=> ovr); // R5

   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovr && !stat_rd |=> ovr); // R6

   AST_TX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      tx_full && dat_wr && !tx_pop && !flush |=> tx_full && $stable(tx_count)); // R8

   AST_DIV_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel && bus_addr == '0 && diva && !tx_pop && !rx_push
      |=> $stable(tx_count) && $stable(rx_count)); // R10

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      tx_count <= CW'(DEPTH) && rx_count <= CW'(DEPTH)); // R8

   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> tx_count == '0 && rx_count == '0); // R11
endmodule

bind uart_dport dport_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_addr  (bus_addr),
   .diva      (lctl[7]),
   .flush     (flush),
   .dat_wr    (dec.dat_wr),
   .dat_rd    (dec.dat_rd),
   .stat_rd   (dec.stat_rd),
   .tx_valid  (tx_valid),
   .tx_pop    (tx_pop),
   .tx_full   (tx_full),
   .tx_count  (tx_count),
   .rx_push   (rx_push),
   .rx_full   (rx_full),
   .rx_count  (rx_count),
   .ovr       (ovr),
   .stat_byte (stat_byte)
);

// File: tb/uart_dport_tb.sv
module uart_dport_tb;
   localparam int DEPTH = 16;
   localparam logic [4:0] A_DATA = 5'd0, A_FCTL = 5'd8, A_LCTL = 5'd12, A_STAT = 5'd20;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        bus_sel = 0, bus_wr = 0, bus_rd = 0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tx_valid;
   logic [7:0]  tx_data;
   logic        tx_pop = 0;
   logic        rx_push = 0;
   logic [7:0]  rx_data = '0;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   logic [7:0] rxq[$];
   logic [7:0] txq[$];
   bit m_qen = 0;
   bit m_ovr = 0;

   always #4 clk = ~clk;

   uart_dport u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
      .rx_push(rx_push), .rx_data(rx_data)
   );

   function automatic int cap();
      return m_qen ? DEPTH : 1;
   endfunction

   function automatic logic [31:0] exp_stat();
      return {26'd0, (txq.size() == 0), 3'd0, m_ovr, (rxq.size() != 0)};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // All tasks start and end at a falling edge.
   task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
      bus_sel = 1; bus_rd = 1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 0; bus_rd = 0;
   endtask

   task automatic m_write(input logic [31:0] d);
      wr_reg(A_DATA, d);
      if (txq.size() < cap()) txq.push_back(d[7:0]);
   endtask

   task automatic m_push(input logic [7:0] d);
      rx_push = 1; rx_data = d;
      @(negedge clk);
      rx_push = 0;
      if (rxq.size() >= cap()) m_ovr = 1;
      else rxq.push_back(d);
   endtask

   task automatic m_read_data(input string req);
      logic [31:0] v;
      logic [31:0] e;
      rd_reg(A_DATA, v);
      e = (rxq.size() != 0) ? {24'd0, rxq.pop_front()} : 32'd0;
      check(req, v, e);
   endtask

   task automatic m_read_stat(input string req);
      logic [31:0] v;
      logic [31:0] e;
      e = exp_stat();
      rd_reg(A_STAT, v);
      m_ovr = 0;
      check(req, v, e);
   endtask

   task automatic m_pop(input string req);
      check(req, {31'd0, tx_valid}, {31'd0, txq.size() != 0});
      if (txq.size() != 0) begin
         check(req, {24'd0, tx_data}, {24'd0, txq[0]});
         tx_pop = 1;
         @(negedge clk);
         tx_pop = 0;
         void'(txq.pop_front());
      end
   endtask

   task automatic m_fctl(input bit en);
      wr_reg(A_FCTL, {31'd0, en});
      m_qen = en;
      rxq.delete();
      txq.delete();
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'h1d5e_0a71));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      rd_reg(A_STAT, v);
      check("R1 status", v, 32'h20);
      check("R1 tx_valid", {31'd0, tx_valid}, 32'd0);

      // R2, R7 single mode: only low byte kept
      m_write(32'hABCD_EF5A);
      check("R7 thre low after write", exp_stat(), 32'h0);
      rd_reg(A_STAT, v);
      check("R7 status after write", v, 32'h00);
      check("R2 tx_data low byte", {24'd0, tx_data}, 32'h5A);
      // R3 second write dropped
      m_write(32'h0000_0011);
      m_pop("R3 first char");
      check("R3 no second char", {31'd0, tx_valid}, 32'd0);
      rd_reg(A_STAT, v);
      check("R7 thre back after pop", v, 32'h20);

      // R5 single mode overrun keeps stored char
      m_push(8'hC3);
      m_push(8'h3C);
      m_read_stat("R5 R6 overrun set single");
      m_read_stat("R6 overrun cleared");
      m_read_data("R5 kept first char, R2 upper zero");
      m_read_data("R4 empty read returns 0");

      // R8, R9 queue mode
      m_fctl(1);
      for (int i = 0; i < DEPTH + 1; i++) m_write(32'hFFFF_FF00 | 32'(8'h40 + i));
      check("R8 queue holds DEPTH", txq.size(), DEPTH);
      for (int i = 0; i < DEPTH; i++) m_pop("R9 R8 order");
      check("R8 17th dropped", {31'd0, tx_valid}, 32'd0);

      // R4, R5 receive queue fill and overrun
      for (int i = 0; i < DEPTH + 1; i++) m_push(8'h80 + 8'(i));
      m_read_stat("R5 queue overrun");
      for (int i = 0; i < DEPTH; i++) m_read_data("R4 order");
      m_read_stat("R6 cleared, R6 no data");

      // R10 divisor redirect
      m_push(8'h77);
      m_write(32'h55);
      wr_reg(A_LCTL, 32'h80);
      wr_reg(A_DATA, 32'h33);
      rd_reg(A_DATA, v);
      check("R10 divisor readback", v, 32'h33);
      check("R10 tx untouched", {24'd0, tx_data}, 32'h55);
      wr_reg(A_LCTL, 32'h00);
      m_read_data("R10 rx untouched");
      m_pop("R10 tx single entry");

      // R11 flush on fifo control write
      m_write(32'h9);
      m_push(8'h1);
      m_fctl(1);
      check("R11 tx flushed", {31'd0, tx_valid}, 32'd0);
      m_read_stat("R11 rx flushed");

      // random mix against the queue model
      for (int n = 0; n < 4000; n++) begin
         int r;
         r = int'($urandom % 100);
         if (r < 24)      m_push(8'($urandom));
         else if (r < 44) m_read_data("R4 random read");
         else if (r < 66) m_write($urandom);
         else if (r < 86) m_pop("R9 random pop");
         else if (r < 98) m_read_stat("R6 random status");
         else             m_fctl(1'($urandom));
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule